// File: doc/BRIEF.md
# Eight-Level Return Address Stack

This block keeps return addresses for a small 4-bit processor core. It holds eight 14-bit program counter values, each a 7-bit page number above a 7-bit in-page address. A 3-bit pointer marks the newest entry. Subroutine calls, table lookups and interrupt entry push the address to return to. Returns pop it back. The pointer is also available as a 4-bit word, so the core can move it into its accumulator.

The pointer starts at 7, so the first push fills entry 0. Pushing past eight levels gives no error: the pointer wraps to 0 and the oldest entry is overwritten. A wake-up input puts the pointer back to 7 and keeps the stored addresses.

A one-deep shadow register sits beside the stack and is used only for interrupts. On interrupt entry it captures the accumulator, the B register, the carry flag, the skip flag and the data pointer. Its outputs always show what it holds, and the core loads them back on interrupt return. Calls and table lookups never touch the shadow register.

Top module: `return_stack`

## Requirements
- R1: While reset is asserted and right after it, the pointer is 7, every stack entry is zero and every shadow output is zero.
- R2: A push alone writes `push_pc` into entry pointer+1 and advances the pointer. After reset, the first push therefore lands in entry 0, and `top_pc` shows the pushed value from the next cycle on.
- R3: `top_pc` always shows the entry at the current pointer. A pop alone decrements the pointer in the next cycle, and the pointer wraps from 0 to 7.
- R4: A push with the pointer at 7 wraps the pointer to 0 and overwrites entry 0. No error is raised.
- R5: When push and pop are requested in the same cycle, the block performs a pop: the pointer decrements and no entry is written.
- R6: `wake` sets the pointer to 7 and leaves all entries unchanged. It overrides push and pop in the same cycle.
- R7: `sp_word` carries the pointer in bits 2:0 and a zero in bit 3.
- R8: `ctx_save` captures `cur_acc`, `cur_b`, `cur_cy`, `cur_skip` and `cur_dp` into the shadow register. The captured values appear on the `ctx_*` outputs from the next cycle on.
- R9: Without `ctx_save` the shadow outputs keep their values, whatever push, pop or wake do. `ctx_save` has no effect on the pointer or on the stack entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Return from back-up mode: pointer back to 7, entries kept |
| push | input | 1 | Push request |
| push_pc | input | 14 | Address to push, page in bits 13:7 and in-page address in bits 6:0 |
| pop | input | 1 | Pop request |
| top_pc | output | 14 | Entry at the current pointer (the value a pop returns) |
| sp_word | output | 4 | Pointer as a 4-bit word, bit 3 always 0 |
| ctx_save | input | 1 | Interrupt entry: capture the core context |
| cur_acc | input | 4 | Accumulator to save |
| cur_b | input | 4 | B register to save |
| cur_cy | input | 1 | Carry flag to save |
| cur_skip | input | 1 | Skip flag to save |
| cur_dp | input | 10 | Data pointer to save (2-bit group, 4-bit file, 4-bit digit) |
| ctx_acc | output | 4 | Saved accumulator |
| ctx_b | output | 4 | Saved B register |
| ctx_cy | output | 1 | Saved carry flag |
| ctx_skip | output | 1 | Saved skip flag |
| ctx_dp | output | 10 | Saved data pointer |

## Verification
A wrong pointer shows on `sp_word` in the very next cycle. It also shows on `top_pc`, which then displays a different entry. A write to the wrong entry shows only later, when the pointer reaches that slot, so the bench pops back through a sequence of distinct values. The overflow wrap and the wake-up cases each leave a pointer value and a top entry that can be predicted exactly. A shadow register that captures at the wrong moment shows on the `ctx_*` outputs one cycle after the stimulus.

// File: rtl/return_stack.sv
module return_stack #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 14,
  parameter int SPO_W = 4,
  parameter int NIB   = 4,
  parameter int DP_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic             push,
  input  logic [PC_W-1:0]  push_pc,
  input  logic             pop,
  output logic [PC_W-1:0]  top_pc,
  output logic [SPO_W-1:0] sp_word,
  input  logic             ctx_save,
  input  logic [NIB-1:0]   cur_acc,
  input  logic [NIB-1:0]   cur_b,
  input  logic             cur_cy,
  input  logic             cur_skip,
  input  logic [DP_W-1:0]  cur_dp,
  output logic [NIB-1:0]   ctx_acc,
  output logic [NIB-1:0]   ctx_b,
  output logic             ctx_cy,
  output logic             ctx_skip,
  output logic [DP_W-1:0]  ctx_dp
);

  localparam int SP_W = $clog2(DEPTH);
  localparam logic [SP_W-1:0] SP_INIT = SP_W'(DEPTH - 1);

  logic [PC_W-1:0] mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_up;
  logic            do_push;
  logic            do_pop;

  assign sp_up   = sp + 1'b1;
  assign do_pop  = pop && !wake;
  assign do_push = push && !pop && !wake;
  assign top_pc  = mem[sp];
  assign sp_word = {{(SPO_W-SP_W){1'b0}}, sp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= SP_INIT;
    else if (wake)    sp <= SP_INIT;
    else if (do_pop)  sp <= sp - 1'b1;
    else if (do_push) sp <= sp_up;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (do_push && sp_up == SP_W'(i)) mem[i] <= push_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_acc <= '0; ctx_b <= '0; ctx_cy <= 1'b0; ctx_skip <= 1'b0; ctx_dp <= '0;
    end else if (ctx_save) begin
      ctx_acc <= cur_acc; ctx_b <= cur_b; ctx_cy <= cur_cy;
      ctx_skip <= cur_skip; ctx_dp <= cur_dp;
    end
  end

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !wake) |=> (top_pc == $past(push_pc)));

  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wake) |=> (sp_word == SPO_W'($past(sp_word) - 1'b1) % SPO_W'(DEPTH)));

  assert_both_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !wake) |=> (top_pc == $past(mem[sp - 1'b1])));

  assert_wake_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (sp_word == SPO_W'(DEPTH - 1)));

  assert_word_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_word[SPO_W-1] == 1'b0);

  assert_ctx_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_save |=> (ctx_acc == $past(cur_acc) && ctx_dp == $past(cur_dp)
                  && ctx_b == $past(cur_b)));

  assert_ctx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_save |=> ($stable(ctx_acc) && $stable(ctx_b) && $stable(ctx_cy)
                   && $stable(ctx_skip) && $stable(ctx_dp)));

endmodule

// File: tb/test_return_stack.sv
module test_return_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake = 1'b0, push = 1'b0, pop = 1'b0, ctx_save = 1'b0;
  logic [13:0] push_pc = '0;
  logic [13:0] top_pc;
  logic [3:0]  sp_word;
  logic [3:0]  cur_acc = '0, cur_b = '0, ctx_acc, ctx_b;
  logic        cur_cy = 1'b0, cur_skip = 1'b0, ctx_cy, ctx_skip;
  logic [9:0]  cur_dp = '0, ctx_dp;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  return_stack i_return_stack (
    .clk, .rst_n, .wake, .push, .push_pc, .pop, .top_pc, .sp_word,
    .ctx_save, .cur_acc, .cur_b, .cur_cy, .cur_skip, .cur_dp,
    .ctx_acc, .ctx_b, .ctx_cy, .ctx_skip, .ctx_dp
  );

  // {push, pop, wake, data[13:0], exp_sp[2:0], exp_top[13:0]}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {3'b100, 14'h0101, 3'd0, 14'h0101},  // R2 first push lands in entry 0
    {3'b100, 14'h0202, 3'd1, 14'h0202},  // R2
    {3'b100, 14'h0303, 3'd2, 14'h0303},  // R2
    {3'b100, 14'h0404, 3'd3, 14'h0404},  // R2
    {3'b100, 14'h0505, 3'd4, 14'h0505},  // R2
    {3'b100, 14'h0606, 3'd5, 14'h0606},  // R2
    {3'b100, 14'h0707, 3'd6, 14'h0707},  // R2
    {3'b100, 14'h0808, 3'd7, 14'h0808},  // R2
    {3'b100, 14'h3FFF, 3'd0, 14'h3FFF},  // R4 ninth push wraps, overwrites entry 0
    {3'b010, 14'h0000, 3'd7, 14'h0808},  // R3 pop wraps 0 to 7
    {3'b110, 14'h1234, 3'd6, 14'h0707},  // R5 push+pop acts as pop
    {3'b010, 14'h0000, 3'd5, 14'h0606},  // R3
    {3'b001, 14'h0000, 3'd7, 14'h0808},  // R6 wake, entries kept
    {3'b101, 14'h0AAA, 3'd7, 14'h0808},  // R6 wake overrides push
    {3'b100, 14'h0111, 3'd0, 14'h0111}   // R4 entry 0 rewritten after wake
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {28'd0, sp_word}, 32'd7);
    check("R1", {18'd0, top_pc}, 32'd0);
    check("R1", {ctx_acc, ctx_b, ctx_cy, ctx_skip, ctx_dp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, sp_word}, 32'd7);
    check("R7", {31'd0, sp_word[3]}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      {push, pop, wake, push_pc} = VEC[k][33:17];
      @(negedge clk);
      push = 1'b0; pop = 1'b0; wake = 1'b0;
      check($sformatf("R2-R6 vector %0d sp", k), {28'd0, sp_word}, {29'd0, VEC[k][16:14]});
      check($sformatf("R2-R6 vector %0d top", k), {18'd0, top_pc}, {18'd0, VEC[k][13:0]});
    end

    // R3: pop back down to entry 0 via distinct values; entry 0 holds 0111
    push_pc = 14'h0222; push = 1'b1; @(negedge clk);
    push_pc = 14'h0333; @(negedge clk);
    push = 1'b0; pop = 1'b1; @(negedge clk);
    check("R3", {18'd0, top_pc}, 32'h0222);
    @(negedge clk);
    pop = 1'b0;
    check("R3", {18'd0, top_pc}, 32'h0111);
    check("R7", {28'd0, sp_word}, 32'd0);

    // R8: capture context
    cur_acc = 4'hA; cur_b = 4'h5; cur_cy = 1'b1; cur_skip = 1'b1; cur_dp = 10'h2C7;
    ctx_save = 1'b1; @(negedge clk);
    ctx_save = 1'b0;
    check("R8", {12'd0, ctx_acc, ctx_b, ctx_cy, ctx_skip, ctx_dp},
          {12'd0, 4'hA, 4'h5, 1'b1, 1'b1, 10'h2C7});
    check("R9 save leaves stack", {28'd0, sp_word}, 32'd0);

    // R9: changes without save, alongside push, pop and wake
    cur_acc = 4'h3; cur_b = 4'hC; cur_cy = 1'b0; cur_skip = 1'b0; cur_dp = 10'h011;
    push = 1'b1; push_pc = 14'h1555; @(negedge clk);
    push = 1'b0; wake = 1'b1; @(negedge clk);
    wake = 1'b0;
    check("R9", {12'd0, ctx_acc, ctx_b, ctx_cy, ctx_skip, ctx_dp},
          {12'd0, 4'hA, 4'h5, 1'b1, 1'b1, 10'h2C7});
    check("R6", {28'd0, sp_word}, 32'd7);

    // R8: save together with push, second capture overwrites
    ctx_save = 1'b1; push = 1'b1; push_pc = 14'h0077; @(negedge clk);
    ctx_save = 1'b0; push = 1'b0;
    check("R8", {12'd0, ctx_acc, ctx_b, ctx_cy, ctx_skip, ctx_dp},
          {12'd0, 4'h3, 4'hC, 1'b0, 1'b0, 10'h011});
    check("R2", {18'd0, top_pc}, 32'h0077);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule